// File: doc/BRIEF.md
# 1-Wire Time-Slot and Bus-Reset Engine

This block is the bit-level core of a 1-Wire bus master. A host hands it a command code with a parameter byte. A single-bit command makes one time slot on the bus. A slot value of zero gives a write-zero slot. A slot value of one gives a write-one slot, which also serves as a read slot. A reset command makes a bus reset: a long low pulse, then a release window in which a responding device's presence pulse, or a shorted line, is detected.

Every duration is a count of system clocks. Each duration has a standard-speed value and an overdrive value, and a speed input chooses between them. The bus line is open-drain: the block only asserts a pull-down request and never drives the line high. It reads the line back through a synchroniser. The host reads the status outputs to poll the busy flag and to collect the sampled bit, the direction bit, and the two reset results. Two configuration inputs request pull-up assistance from circuitry outside the block: a short boost after each release inside a slot, and a strong pull-up after the slot ends.

Top module: `owb_engine`

## Requirements
- R1: After reset, `lineDrive`, `activePull`, `strongPull`, `busy`, `sbr`, `dir`, `presence` and `shortDet` are all 0.
- R2: While `busy` is 0, a command with code 0x87 (slot) or 0xB4 (reset) raises `cmdAck` in the same cycle. `busy` is 1 from the next cycle, and the bus activity starts in that same next cycle.
- R3: For a slot, `busy` is high for exactly SLOT cycles: SLOT_STD, or SLOT_OD in overdrive.
- R4: The slot value V is bit 7 of `cmdParam`. V=0 asserts `lineDrive` for the first LOW0 cycles of the slot, and V=1 for the first LOW1 cycles. Bits 6 to 0 of `cmdParam` have no effect.
- R5: `sbr` takes the synchronised line level at slot cycle SAMP, counted from 0. The line is high for 1 and low for 0.
- R6: `dir` takes V from each accepted slot command. A reset command leaves it unchanged.
- R7: While `busy` is 1, any command gets `cmdAck`=0 and does not change the running operation. A code other than 0x87 or 0xB4 gets `cmdAck`=0 and starts nothing.
- R8: When a command is accepted, the value of `cfgSpeed` at that moment selects standard timing (0) or overdrive timing (1) for the whole operation. Later changes to `cfgSpeed` have no effect on it.
- R9: A reset asserts `lineDrive` for RSTL cycles and then releases the line for RSTH cycles. `busy` is high for RSTL+RSTH cycles.
- R10: If the synchronised line is low at release-window cycle SHORT_CHK, `shortDet` becomes 1 and `presence` stays 0.
- R11: When no short was found, a low level seen later in the release window sets `presence`. Both `presence` and `shortDet` clear when the next reset is accepted.
- R12: When `cfgApu` was 1 at acceptance, `activePull` is high for exactly BOOST cycles. These cycles follow immediately after `lineDrive` drops inside a slot. When `cfgApu` was 0, `activePull` never rises. `activePull` and `lineDrive` are never high together.
- R13: When `cfgSpu` was 1 at acceptance of a slot, `strongPull` is 1 from the end of that slot until the next command is accepted. When `cfgSpu` was 0, `strongPull` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdCode | input | 8 | Command code (0x87 slot, 0xB4 reset) |
| cmdParam | input | 8 | Parameter byte; bit 7 is the slot value |
| cmdAck | output | 1 | Command accepted this cycle |
| cfgSpeed | input | 1 | 0 standard, 1 overdrive timing |
| cfgApu | input | 1 | Request the boost after release in slots |
| cfgSpu | input | 1 | Request the strong pull-up after a slot |
| lineIn | input | 1 | Bus line level as read |
| lineDrive | output | 1 | Pull-down request for the bus line |
| activePull | output | 1 | Boost pull-up request |
| strongPull | output | 1 | Strong pull-up request |
| busy | output | 1 | Operation in progress |
| sbr | output | 1 | Sampled slot bit |
| dir | output | 1 | Slot value of the last slot |
| presence | output | 1 | Presence pulse detected in the last reset |
| shortDet | output | 1 | Short detected in the last reset |

## Verification
The slot sweep covers both speeds, both slot values, a device that either holds the line low past the sample point or stays silent, four patterns in the parameter's low seven bits, and both boost settings. Together these tell apart a wrong duration table, a wrong low-time selection, a sample taken at the wrong point, and a dependence on ignored bits. While each slot runs, a second command is offered and the speed input is toggled, which separates real rejection and latching from accidental acceptance. The reset sequence at each speed runs no device, then a presence pulse, then a held-low line, then presence again, then no device. This order shows that short and presence exclude each other and that both clear at the next reset.

// File: rtl/owb_pkg.sv
package owb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SLOT,
    ST_RLOW,
    ST_RHIGH
  } owbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startSlot;
    logic startRst;
    logic cntClr;
    logic inSlot;
    logic inRstLow;
    logic inRstHigh;
    logic slotDone;
  } owbCtl_t;

  // timing flags from datapath to control
  typedef struct packed {
    logic slotEnd;
    logic rstLowEnd;
    logic rstHighEnd;
  } owbTim_t;

  localparam logic [7:0] CMD_BIT   = 8'h87;
  localparam logic [7:0] CMD_RESET = 8'hB4;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owb_control.sv
module owb_control
  import owb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  owbTim_t    tim,
  output owbCtl_t    ctl,
  output logic       cmdAck,
  output logic       busy
);

  owbState_t state, stateNext;
  logic isSlotCode, isRstCode;

  assign isSlotCode = (cmdCode == CMD_BIT);
  assign isRstCode  = (cmdCode == CMD_RESET);
  assign busy       = (state != ST_IDLE);
  assign cmdAck     = cmdValid && (isSlotCode || isRstCode) && (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdAck) stateNext = isSlotCode ? ST_SLOT : ST_RLOW;
      end
      ST_SLOT:  if (tim.slotEnd)    stateNext = ST_IDLE;
      ST_RLOW:  if (tim.rstLowEnd)  stateNext = ST_RHIGH;
      ST_RHIGH: if (tim.rstHighEnd) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl.startSlot = cmdAck && isSlotCode;
    ctl.startRst  = cmdAck && isRstCode;
    ctl.cntClr    = cmdAck || ((state == ST_RLOW) && tim.rstLowEnd);
    ctl.inSlot    = (state == ST_SLOT);
    ctl.inRstLow  = (state == ST_RLOW);
    ctl.inRstHigh = (state == ST_RHIGH);
    ctl.slotDone  = (state == ST_SLOT) && tim.slotEnd;
  end

  // an accepted command always leads to a busy operation
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdAck |=> busy);

  // no acceptance while an operation runs
  assert_busy_no_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cmdAck);

  // reset release phase always follows the low phase
  assert_rst_order_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RLOW && tim.rstLowEnd) |=> (state == ST_RHIGH));

endmodule

// File: rtl/owb_datapath.sv
module owb_datapath
  import owb_pkg::*;
#(
  parameter int SLOT_STD    = 3500,
  parameter int LOW0_STD    = 3000,
  parameter int LOW1_STD    = 300,
  parameter int SAMP_STD    = 750,
  parameter int RSTL_STD    = 28000,
  parameter int RSTH_STD    = 28000,
  parameter int SLOT_OD     = 500,
  parameter int LOW0_OD     = 400,
  parameter int LOW1_OD     = 50,
  parameter int SAMP_OD     = 100,
  parameter int RSTL_OD     = 3500,
  parameter int RSTH_OD     = 3500,
  parameter int SHORT_CHK   = 100,
  parameter int BOOST       = 125,
  parameter int SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rstN,
  input  owbCtl_t    ctl,
  input  logic [7:0] cmdParam,
  input  logic       cfgSpeed,
  input  logic       cfgApu,
  input  logic       cfgSpu,
  input  logic       lineIn,
  output owbTim_t    tim,
  output logic       lineDrive,
  output logic       activePull,
  output logic       strongPull,
  output logic       sbr,
  output logic       dir,
  output logic       presence,
  output logic       shortDet
);

  localparam int MAX_SLOT = maxOf(SLOT_STD, SLOT_OD);
  localparam int MAX_RST  = maxOf(maxOf(RSTL_STD, RSTH_STD), maxOf(RSTL_OD, RSTH_OD));
  localparam int MAX_LOWB = maxOf(LOW0_STD, LOW0_OD) + BOOST;
  localparam int MAXT     = maxOf(maxOf(MAX_SLOT, MAX_RST), MAX_LOWB);
  localparam int CW       = $clog2(MAXT + 1);

  localparam logic [CW-1:0] SLOT_S_L = CW'(SLOT_STD - 1);
  localparam logic [CW-1:0] SLOT_O_L = CW'(SLOT_OD - 1);
  localparam logic [CW-1:0] RSTL_S_L = CW'(RSTL_STD - 1);
  localparam logic [CW-1:0] RSTL_O_L = CW'(RSTL_OD - 1);
  localparam logic [CW-1:0] RSTH_S_L = CW'(RSTH_STD - 1);
  localparam logic [CW-1:0] RSTH_O_L = CW'(RSTH_OD - 1);
  localparam logic [CW-1:0] LOW0_S   = CW'(LOW0_STD);
  localparam logic [CW-1:0] LOW0_O   = CW'(LOW0_OD);
  localparam logic [CW-1:0] LOW1_S   = CW'(LOW1_STD);
  localparam logic [CW-1:0] LOW1_O   = CW'(LOW1_OD);
  localparam logic [CW-1:0] SAMP_S   = CW'(SAMP_STD);
  localparam logic [CW-1:0] SAMP_O   = CW'(SAMP_OD);
  localparam logic [CW-1:0] SHORT_C  = CW'(SHORT_CHK);
  localparam logic [CW-1:0] BOOST_C  = CW'(BOOST);

  logic [CW-1:0] cnt;
  logic          speedQ, apuQ, spuQ;
  logic          active, lineS;
  logic [CW-1:0] slotLast, rstlLast, rsthLast, lowT, sampT, boostEnd;

  // two-flop (or deeper) line synchroniser, idle level high
  logic [SYNC_STAGES-1:0] syncQ;
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= lineIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      end
    end
  endgenerate
  assign lineS = syncQ[SYNC_STAGES-1];

  // timing table selected by the latched speed
  always_comb begin
    slotLast = speedQ ? SLOT_O_L : SLOT_S_L;
    rstlLast = speedQ ? RSTL_O_L : RSTL_S_L;
    rsthLast = speedQ ? RSTH_O_L : RSTH_S_L;
    sampT    = speedQ ? SAMP_O   : SAMP_S;
    if (dir) lowT = speedQ ? LOW1_O : LOW1_S;
    else     lowT = speedQ ? LOW0_O : LOW0_S;
    boostEnd = lowT + BOOST_C;
  end

  assign active = ctl.inSlot || ctl.inRstLow || ctl.inRstHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.cntClr) cnt <= '0;
    else if (active)     cnt <= cnt + 1'b1;
  end

  // configuration and slot value captured at acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      speedQ <= 1'b0;
      apuQ   <= 1'b0;
      spuQ   <= 1'b0;
      dir    <= 1'b0;
    end else begin
      if (ctl.startSlot || ctl.startRst) begin
        speedQ <= cfgSpeed;
        apuQ   <= cfgApu;
        spuQ   <= cfgSpu;
      end
      if (ctl.startSlot) dir <= cmdParam[7];
    end
  end

  always_comb begin
    tim.slotEnd    = (cnt == slotLast);
    tim.rstLowEnd  = (cnt == rstlLast);
    tim.rstHighEnd = (cnt == rsthLast);
  end

  assign lineDrive  = (ctl.inSlot && (cnt < lowT)) || ctl.inRstLow;
  assign activePull = apuQ && ctl.inSlot && (cnt >= lowT) && (cnt < boostEnd);

  // sampled slot bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           sbr <= 1'b0;
    else if (ctl.inSlot && cnt == sampT) sbr <= lineS;
  end

  // reset window results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shortDet <= 1'b0;
      presence <= 1'b0;
    end else if (ctl.startRst) begin
      shortDet <= 1'b0;
      presence <= 1'b0;
    end else if (ctl.inRstHigh && !lineS) begin
      if (cnt == SHORT_C)                 shortDet <= 1'b1;
      else if (cnt > SHORT_C && !shortDet) presence <= 1'b1;
    end
  end

  // strong pull-up after a slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         strongPull <= 1'b0;
    else if (ctl.startSlot || ctl.startRst) strongPull <= 1'b0;
    else if (ctl.slotDone && spuQ)     strongPull <= 1'b1;
  end

  assert_slot_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.inSlot |-> (cnt <= slotLast));

  assert_short_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    shortDet |-> !presence);

  assert_boost_release_R12: assert property (@(posedge clk) disable iff (!rstN)
    activePull |-> !lineDrive);

  assert_strong_idle_R13: assert property (@(posedge clk) disable iff (!rstN)
    strongPull |-> !active);

  assert_sbr_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inSlot && cnt != sampT) |=> $stable(sbr));

endmodule

// File: rtl/owb_engine.sv
module owb_engine
  import owb_pkg::*;
#(
  parameter int SLOT_STD    = 3500,
  parameter int LOW0_STD    = 3000,
  parameter int LOW1_STD    = 300,
  parameter int SAMP_STD    = 750,
  parameter int RSTL_STD    = 28000,
  parameter int RSTH_STD    = 28000,
  parameter int SLOT_OD     = 500,
  parameter int LOW0_OD     = 400,
  parameter int LOW1_OD     = 50,
  parameter int SAMP_OD     = 100,
  parameter int RSTL_OD     = 3500,
  parameter int RSTH_OD     = 3500,
  parameter int SHORT_CHK   = 100,
  parameter int BOOST       = 125,
  parameter int SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic [7:0] cmdParam,
  output logic       cmdAck,
  input  logic       cfgSpeed,
  input  logic       cfgApu,
  input  logic       cfgSpu,
  input  logic       lineIn,
  output logic       lineDrive,
  output logic       activePull,
  output logic       strongPull,
  output logic       busy,
  output logic       sbr,
  output logic       dir,
  output logic       presence,
  output logic       shortDet
);

  owbCtl_t ctl;
  owbTim_t tim;

  owb_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .tim      (tim),
    .ctl      (ctl),
    .cmdAck   (cmdAck),
    .busy     (busy)
  );

  owb_datapath #(
    .SLOT_STD (SLOT_STD), .LOW0_STD (LOW0_STD), .LOW1_STD (LOW1_STD),
    .SAMP_STD (SAMP_STD), .RSTL_STD (RSTL_STD), .RSTH_STD (RSTH_STD),
    .SLOT_OD  (SLOT_OD),  .LOW0_OD  (LOW0_OD),  .LOW1_OD  (LOW1_OD),
    .SAMP_OD  (SAMP_OD),  .RSTL_OD  (RSTL_OD),  .RSTH_OD  (RSTH_OD),
    .SHORT_CHK(SHORT_CHK), .BOOST   (BOOST),    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cmdParam   (cmdParam),
    .cfgSpeed   (cfgSpeed),
    .cfgApu     (cfgApu),
    .cfgSpu     (cfgSpu),
    .lineIn     (lineIn),
    .tim        (tim),
    .lineDrive  (lineDrive),
    .activePull (activePull),
    .strongPull (strongPull),
    .sbr        (sbr),
    .dir        (dir),
    .presence   (presence),
    .shortDet   (shortDet)
  );

  // the line is never pulled down while idle
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineDrive);

endmodule

// File: tb/owb_engine_bench.sv
`timescale 1ns/1ps
module owb_engine_bench;

  localparam int SLOT_S = 40, LOW0_S = 30, LOW1_S = 4, SAMP_S = 10, RSTL_S = 60, RSTH_S = 60;
  localparam int SLOT_O = 20, LOW0_O = 15, LOW1_O = 2, SAMP_O = 5,  RSTL_O = 30, RSTH_O = 30;
  localparam int SHORTC = 3,  BOOSTC = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [7:0] cmdCode = 8'h00, cmdParam = 8'h00;
  logic cfgSpeed = 1'b0, cfgApu = 1'b0, cfgSpu = 1'b0;
  logic slaveLow = 1'b0;
  logic cmdAck, lineDrive, activePull, strongPull, busy, sbr, dir, presence, shortDet;
  logic lineWire;

  int errors = 0, checks = 0;

  always #10 clk = ~clk;   // 50 MHz

  assign lineWire = !(lineDrive || slaveLow);

  owb_engine #(
    .SLOT_STD(SLOT_S), .LOW0_STD(LOW0_S), .LOW1_STD(LOW1_S), .SAMP_STD(SAMP_S),
    .RSTL_STD(RSTL_S), .RSTH_STD(RSTH_S),
    .SLOT_OD(SLOT_O), .LOW0_OD(LOW0_O), .LOW1_OD(LOW1_O), .SAMP_OD(SAMP_O),
    .RSTL_OD(RSTL_O), .RSTH_OD(RSTH_O),
    .SHORT_CHK(SHORTC), .BOOST(BOOSTC), .SYNC_STAGES(2)
  ) u_owb_engine (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdParam(cmdParam),
    .cmdAck(cmdAck), .cfgSpeed(cfgSpeed), .cfgApu(cfgApu), .cfgSpu(cfgSpu),
    .lineIn(lineWire), .lineDrive(lineDrive), .activePull(activePull),
    .strongPull(strongPull), .busy(busy), .sbr(sbr), .dir(dir),
    .presence(presence), .shortDet(shortDet)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one slot command with a device model, measured cycle by cycle
  task automatic runSlot(input bit spd, input bit v, input bit devLow,
                         input logic [6:0] low7, input bit apu, input bit spu);
    int busyCnt = 0, lowCnt = 0, boostCnt = 0, overlap = 0;
    int slotT = spd ? SLOT_O : SLOT_S;
    int lowT  = v ? (spd ? LOW1_O : LOW1_S) : (spd ? LOW0_O : LOW0_S);
    int sampT = spd ? SAMP_O : SAMP_S;
    int expSbr = (v && !devLow) ? 1 : 0;
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 8'h87; cmdParam = {v, low7};
    cfgSpeed = spd; cfgApu = apu; cfgSpu = spu;
    #1 chk("R2 slot ack", int'(cmdAck), 1);
    for (int i = 1; i < 200; i++) begin
      @(negedge clk);
      cmdValid = 1'b0;
      slaveLow = devLow && v && (i <= sampT + 3);
      if (i == 2) cfgSpeed = ~spd;
      if (i == 1) chk("R13 strong cleared at accept", int'(strongPull), 0);
      if (i == 3) begin
        cmdValid = 1'b1; cmdCode = (spd ? 8'hB4 : 8'h87); cmdParam = 8'h00;
        #1 chk("R7 busy reject", int'(cmdAck), 0);
      end
      if (!busy) break;
      busyCnt++;
      if (lineDrive) lowCnt++;
      if (activePull) boostCnt++;
      if (activePull && lineDrive) overlap++;
    end
    cmdValid = 1'b0; slaveLow = 1'b0; cfgSpeed = spd;
    chk("R3 R8 slot busy length", busyCnt, slotT);
    chk("R4 R8 low length", lowCnt, lowT);
    chk("R12 boost length", boostCnt, apu ? BOOSTC : 0);
    chk("R12 boost overlap", overlap, 0);
    chk("R5 sampled bit", int'(sbr), expSbr);
    chk("R6 direction", int'(dir), int'(v));
    chk("R13 strong after slot", int'(strongPull), int'(spu));
  endtask

  // mode: 0 silent, 1 presence pulse, 2 line held low
  task automatic runReset(input bit spd, input int mode);
    int busyCnt = 0, lowCnt = 0;
    int rl = spd ? RSTL_O : RSTL_S;
    int rh = spd ? RSTH_O : RSTH_S;
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 8'hB4; cmdParam = 8'hFF; cfgSpeed = spd;
    #1 chk("R2 reset ack", int'(cmdAck), 1);
    for (int i = 1; i < 400; i++) begin
      @(negedge clk);
      cmdValid = 1'b0;
      if (i == 2) cfgSpeed = ~spd;
      if (mode == 2) slaveLow = 1'b1;
      else if (mode == 1) slaveLow = (i >= rl + 8) && (i <= rl + 18);
      else slaveLow = 1'b0;
      if (!busy) break;
      busyCnt++;
      if (lineDrive) lowCnt++;
    end
    slaveLow = 1'b0; cfgSpeed = spd;
    chk("R9 R8 reset low length", lowCnt, rl);
    chk("R9 reset busy length", busyCnt, rl + rh);
    chk("R10 short flag", int'(shortDet), (mode == 2) ? 1 : 0);
    chk("R11 presence flag", int'(presence), (mode == 1) ? 1 : 0);
  endtask

  initial begin : watchdog
    #3000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [6:0] pats [4];
    pats[0] = 7'h00; pats[1] = 7'h7F; pats[2] = 7'h55; pats[3] = 7'h2A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 lineDrive", int'(lineDrive), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 pulls", int'(activePull | strongPull), 0);
    chk("R1 status", int'({sbr, dir, presence, shortDet}), 0);

    // unknown code while idle
    cmdValid = 1'b1; cmdCode = 8'h12; cmdParam = 8'h80;
    #1 chk("R7 unknown code ack", int'(cmdAck), 0);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R7 unknown code no busy", int'(busy), 0);
    chk("R7 unknown code no drive", int'(lineDrive), 0);

    for (int s = 0; s < 2; s++)
      for (int v = 0; v < 2; v++)
        for (int d = 0; d < 2; d++)
          for (int p = 0; p < 4; p++)
            for (int a = 0; a < 2; a++)
              runSlot(s[0], v[0], d[0], pats[p], a[0], p[0]);

    for (int s = 0; s < 2; s++) begin
      runReset(s[0], 0);
      runReset(s[0], 1);
      runReset(s[0], 2);
      runReset(s[0], 1);
      runReset(s[0], 0);
    end

    // R6: a reset leaves dir from the last slot
    runSlot(1'b0, 1'b1, 1'b0, 7'h00, 1'b0, 1'b0);
    runReset(1'b1, 0);
    chk("R6 dir kept over reset", int'(dir), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule